// File: doc/BRIEF.md
# Bipolar Converter Serial Port

This block is the device-side digital half of the serial interface of a four-channel, 12-bit-plus-sign converter. The host pulls chip select low. It then gives sixteen serial clocks that idle high. On each falling edge the block takes in one command bit and sends out one result bit. The data output is valid only while a frame is open. The host releases it after the sixteenth falling edge, or at once if chip select rises early.

The first three command bits are a header. The first bit enables a write, and the next two bits pick the target register. A write to the 12-bit control register is committed on the 15th falling edge. A write to one of the two 8-bit registers (range and sequence) is committed on the 11th falling edge. If the frame is aborted before the load edge of the addressed register, that register keeps its old value.

The result word goes out in this order: a zero bit, two channel-tag bits, the sign bit, and then a 12-bit magnitude, most significant bit first. The block also drives a hold strobe for the analog sampler. The serial pins are brought into the system clock domain through synchronizers, so the system clock must run at least four times as fast as the serial clock.

Top module: `sadc_port`

## Requirements
- R1: After reset, `doutEn` and `holdOut` are 0, and `ctrlReg`, `rangeReg` and `seqReg` are all zero.
- R2: A falling edge of `csN` sets `doutEn` to 1 and `holdOut` to 1 (hold), and drives `dout` to 0 (the lead bit).
- R3: After the k-th serial-clock falling edge of a frame (k = 1 to 15), `dout` carries bit 15−k of the word {0, `convChan`[1:0], `convResult`[12:0]}. That word is captured when chip select falls, and `convResult`[12] is the sign.
- R4: On the 16th falling edge, `doutEn` returns to 0. Serial-clock edges that arrive after this have no effect until the next chip-select fall.
- R5: `holdOut` stays 1 until the 14th serial-clock rising edge of the frame, and then returns to 0 (track).
- R6: Command stream bit 1 (the first bit sent) is the write enable. Bits 2 and 3 select the register: 00 selects control, 01 selects range, 10 selects sequence, and 11 selects none. For range or sequence with write enable 1, stream bits 4 to 11 (MSB first) are loaded on the 11th falling edge.
- R7: For control with write enable 1, stream bits 4 to 15 (MSB first) are loaded into `ctrlReg` on the 15th falling edge.
- R8: A write-enable bit of 0, or a select value of 11, leaves all three registers unchanged.
- R9: If `csN` rises before the 16th falling edge, `doutEn` and `holdOut` go to 0. A register whose load edge was not reached keeps its old value, and one whose load edge was already passed keeps its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| csN | input | 1 | Active-low chip select |
| din | input | 1 | Serial command data |
| convChan | input | 2 | Channel tag of the current result |
| convResult | input | 13 | Sign bit (MSB) and 12-bit magnitude from the converter core |
| dout | output | 1 | Serial result data |
| doutEn | output | 1 | Output driver enable; 0 means high impedance |
| holdOut | output | 1 | Sampler strobe: 1 = hold, 0 = track |
| ctrlReg | output | 12 | Control register |
| rangeReg | output | 8 | Range register |
| seqReg | output | 8 | Sequence register |

## Verification
A wrong bit counter in this block shows up in two places. The lead, tag and result bits become misaligned within one serial clock of the error. Registers also commit at the wrong edge, and this is visible at the register ports directly after an aborted frame. A driver-enable or hold state that does not clear is seen on the very next sample after the 16th falling edge, the 14th rising edge, or an early chip-select release. Every one of these port effects follows its pin edge by a fixed number of system cycles, three or fewer, and the bench samples well after that delay.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Strobes issued by the frame controller to the datapath, one cycle wide.
  typedef struct packed {
    logic start;      // chip select fell: capture result, clear input shifter
    logic shift;      // serial clock fell inside an open frame
    logic loadSmall;  // this fall is the load edge of the 8-bit registers
    logic loadCtrl;   // this fall is the load edge of the control register
  } strobe_t;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'b00,
    SEL_RANGE = 2'b01,
    SEL_SEQ   = 2'b10,
    SEL_NONE  = 2'b11
  } reg_sel_e;

  localparam int HDR_W = 3;  // write enable plus two select bits

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= asyncIn;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int DATA_W = 12,
  parameter int SMALL_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkQ,
  input  logic    csNQ,
  output strobe_t st,
  output logic    doutEn,
  output logic    holdOut
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] TRACK_CNT = CNT_W'(FRAME_LEN - 2);
  localparam logic [CNT_W-1:0] SMALL_CNT = CNT_W'(HDR_W + SMALL_W);
  localparam logic [CNT_W-1:0] CTRL_CNT  = CNT_W'(HDR_W + DATA_W);

  logic             sclkPrev, csPrev, active;
  logic [CNT_W-1:0] fallCnt, riseCnt, nextFall, nextRise;
  logic             fallE, riseE, csFallE, csRiseE;

  assign fallE    = sclkPrev & ~sclkQ;
  assign riseE    = ~sclkPrev & sclkQ;
  assign csFallE  = csPrev & ~csNQ;
  assign csRiseE  = ~csPrev & csNQ;
  assign nextFall = fallCnt + 1'b1;
  assign nextRise = riseCnt + 1'b1;

  always_comb begin
    st           = '0;
    st.start     = csFallE;
    st.shift     = active & fallE & ~csRiseE & ~csFallE;
    st.loadSmall = st.shift && (nextFall == SMALL_CNT);
    st.loadCtrl  = st.shift && (nextFall == CTRL_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      csPrev   <= 1'b1;
      active   <= 1'b0;
      fallCnt  <= '0;
      riseCnt  <= '0;
      doutEn   <= 1'b0;
      holdOut  <= 1'b0;
    end else begin
      sclkPrev <= sclkQ;
      csPrev   <= csNQ;
      if (csFallE) begin
        active  <= 1'b1;
        fallCnt <= '0;
        riseCnt <= '0;
        doutEn  <= 1'b1;
        holdOut <= 1'b1;
      end else if (active) begin
        if (csRiseE) begin
          active  <= 1'b0;
          doutEn  <= 1'b0;
          holdOut <= 1'b0;
        end else begin
          if (fallE) begin
            fallCnt <= nextFall;
            if (nextFall == LAST_CNT) begin
              active <= 1'b0;
              doutEn <= 1'b0;
            end
          end
          if (riseE) begin
            riseCnt <= nextRise;
            if (nextRise == TRACK_CNT) holdOut <= 1'b0;
          end
        end
      end
    end
  end

  // R2: a chip-select fall opens the driver and holds the sampler
  p_start_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    csFallE |=> (doutEn && holdOut));

  // R4: the last falling edge closes the driver
  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.shift && nextFall == LAST_CNT) |=> !doutEn);

  // R5: the track edge releases the hold strobe
  p_track_r5: assert property (@(posedge clk) disable iff (!rstN)
    (active && riseE && !csRiseE && !csFallE && nextRise == TRACK_CNT) |=> !holdOut);

  // R9: an early chip-select release closes everything
  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (active && csRiseE && !csFallE) |=> (!doutEn && !holdOut));

  // R6: at most one load strobe per cycle
  p_one_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.loadSmall, st.loadCtrl}));

endmodule

// File: rtl/sadc_dp.sv
module sadc_dp
  import sadc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SMALL_W = 8,
  parameter int CHAN_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic               dinQ,
  input  logic [CHAN_W-1:0]  convChan,
  input  logic [DATA_W:0]    convResult,
  output logic               doutBit,
  output logic [DATA_W-1:0]  ctrlReg,
  output logic [SMALL_W-1:0] rangeReg,
  output logic [SMALL_W-1:0] seqReg
);

  localparam int FRAME_W = 1 + CHAN_W + 1 + DATA_W;
  localparam int CTRL_W  = HDR_W + DATA_W;   // bits held at the control load edge
  localparam int SMALL_E = HDR_W + SMALL_W;  // bits held at the small load edge

  logic [FRAME_W-1:0] outShift;
  logic [CTRL_W-2:0]  inShift;
  logic [CTRL_W-1:0]  nextIn;
  reg_sel_e           smallSel, ctrlSel;

  assign nextIn   = {inShift, dinQ};
  assign smallSel = reg_sel_e'(nextIn[SMALL_E-2 -: 2]);
  assign ctrlSel  = reg_sel_e'(nextIn[CTRL_W-2 -: 2]);
  assign doutBit  = outShift[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      inShift  <= '0;
    end else if (st.start) begin
      outShift <= {1'b0, convChan, convResult};
      inShift  <= '0;
    end else if (st.shift) begin
      outShift <= {outShift[FRAME_W-2:0], 1'b0};
      inShift  <= nextIn[CTRL_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeReg <= '0;
      seqReg   <= '0;
    end else if (st.loadSmall && nextIn[SMALL_E-1]) begin
      if (smallSel == SEL_RANGE) rangeReg <= nextIn[SMALL_W-1:0];
      if (smallSel == SEL_SEQ)   seqReg   <= nextIn[SMALL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (st.loadCtrl && nextIn[CTRL_W-1] && ctrlSel == SEL_CTRL)
      ctrlReg <= nextIn[DATA_W-1:0];
  end

  // R2: the lead bit is zero
  p_lead_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.start |=> !doutBit);

  // R7: control changes only at its load edge
  p_ctrl_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadCtrl |=> $stable(ctrlReg));

  // R6: range and sequence change only at their load edge
  p_small_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadSmall |=> ($stable(rangeReg) && $stable(seqReg)));

  // R8: a cleared write enable blocks every load
  p_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((st.loadCtrl && !nextIn[CTRL_W-1]) || (st.loadSmall && !nextIn[SMALL_E-1]))
      |=> ($stable(ctrlReg) && $stable(rangeReg) && $stable(seqReg)));

endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int DATA_W = 12,
  parameter int SMALL_W = 8,
  parameter int CHAN_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclk,
  input  logic               csN,
  input  logic               din,
  input  logic [CHAN_W-1:0]  convChan,
  input  logic [DATA_W:0]    convResult,
  output logic               dout,
  output logic               doutEn,
  output logic               holdOut,
  output logic [DATA_W-1:0]  ctrlReg,
  output logic [SMALL_W-1:0] rangeReg,
  output logic [SMALL_W-1:0] seqReg
);

  logic [2:0] pinsQ;
  strobe_t    st;

  sadc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn({sclk, csN, din}), .syncOut(pinsQ)
  );

  sadc_ctrl #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W), .SMALL_W(SMALL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkQ(pinsQ[2]), .csNQ(pinsQ[1]),
    .st(st), .doutEn(doutEn), .holdOut(holdOut)
  );

  sadc_dp #(.DATA_W(DATA_W), .SMALL_W(SMALL_W), .CHAN_W(CHAN_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .dinQ(pinsQ[0]),
    .convChan(convChan), .convResult(convResult), .doutBit(dout),
    .ctrlReg(ctrlReg), .rangeReg(rangeReg), .seqReg(seqReg)
  );

endmodule

// File: tb/sadc_port_test.sv
module sadc_port_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, sclk = 1'b1, csN = 1'b1, din = 1'b0;
  logic [1:0]  convChan = '0;
  logic [12:0] convResult = '0;
  logic dout, doutEn, holdOut;
  logic [11:0] ctrlReg;
  logic [7:0]  rangeReg, seqReg;

  sadc_port uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .convChan(convChan), .convResult(convResult), .dout(dout),
    .doutEn(doutEn), .holdOut(holdOut), .ctrlReg(ctrlReg),
    .rangeReg(rangeReg), .seqReg(seqReg)
  );

  int errs = 0, checks = 0;
  logic [11:0] mCtrl = '0;
  logic [7:0]  mRange = '0, mSeq = '0;

  typedef struct {
    logic  en;
    logic  d;
    logic  h;
    string tag;
  } exp_t;
  exp_t q[$];
  event sampleEv;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic en, input logic d, input logic h, input string tag);
    exp_t e;
    e.en = en; e.d = d; e.h = h; e.tag = tag;
    q.push_back(e);
    -> sampleEv;
  endtask

  // monitor: compares port values against queued expectations
  initial forever begin
    @(sampleEv);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(doutEn === e.en, {e.tag, " doutEn"}, 32'(doutEn), 32'(e.en));
      check(holdOut === e.h, {e.tag, " holdOut"}, 32'(holdOut), 32'(e.h));
      if (e.en) check(dout === e.d, {e.tag, " dout"}, 32'(dout), 32'(e.d));
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkRegs(input string tag);
    check(ctrlReg === mCtrl, {tag, " ctrlReg"}, 32'(ctrlReg), 32'(mCtrl));
    check(rangeReg === mRange, {tag, " rangeReg"}, 32'(rangeReg), 32'(mRange));
    check(seqReg === mSeq, {tag, " seqReg"}, 32'(seqReg), 32'(mSeq));
  endtask

  // one frame of n falling edges, then chip select rises
  task automatic frame(input logic [15:0] w, input int n, input logic [1:0] ch,
                       input logic [12:0] res, input string tag);
    logic [15:0] f;
    f = {1'b0, ch, res};
    convChan = ch;
    convResult = res;
    ticks(1);
    csN = 1'b0;
    din = w[15];
    ticks(5);
    push(1'b1, 1'b0, 1'b1, "R2 lead");
    ticks(1);
    for (int k = 1; k <= n; k++) begin
      sclk = 1'b0;
      ticks(5);
      push(k < 16, (k < 16) ? f[15-k] : 1'b0, k <= 14, (k < 16) ? "R3 bit" : "R4 end");
      ticks(1);
      sclk = 1'b1;
      if (k < 16) din = w[15-k];
      ticks(5);
      push(k < 16, (k < 16) ? f[15-k] : 1'b0, k < 14, (k == 14) ? "R5 track" : "R3 hold");
      ticks(1);
    end
    csN = 1'b1;
    ticks(5);
    push(1'b0, 1'b0, 1'b0, (n < 16) ? "R9 abort" : "R4 idle");
    ticks(1);
    if (w[15]) begin
      if (w[14:13] == 2'b00 && n >= 15) mCtrl = w[12:1];
      if (w[14:13] == 2'b01 && n >= 11) mRange = w[12:5];
      if (w[14:13] == 2'b10 && n >= 11) mSeq = w[12:5];
    end
    checkRegs(tag);
  endtask

  bit done = 1'b0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    ticks(5);
    rstN = 1'b1;
    ticks(4);
    push(1'b0, 1'b0, 1'b0, "R1 reset");
    checkRegs("R1 reset");
    ticks(1);

    frame({3'b100, 12'hA5C, 1'b0}, 16, 2'd2, 13'h1ABC, "R7 control write");
    frame({3'b101, 8'h3C, 5'b0}, 16, 2'd1, 13'h0F0F, "R6 range write");
    frame({3'b110, 8'hC3, 5'h1F}, 16, 2'd3, 13'h1555, "R6 sequence write");
    frame({3'b000, 12'hFFF, 1'b1}, 16, 2'd0, 13'h0AAA, "R8 write disabled");
    frame({3'b111, 12'h0F0, 1'b1}, 16, 2'd1, 13'h1001, "R8 select none");
    frame({3'b100, 12'h123, 1'b0}, 13, 2'd2, 13'h0001, "R9 control abort early");
    frame({3'b101, 8'h77, 5'b0}, 12, 2'd0, 13'h1FFF, "R9 range past edge");
    frame({3'b110, 8'h99, 5'b0}, 10, 2'd3, 13'h0800, "R9 sequence before edge");
    frame({3'b100, 12'h6E1, 1'b0}, 15, 2'd1, 13'h0C3C, "R9 control at edge");
    frame({3'b101, 8'hFF, 5'b0}, 2, 2'd2, 13'h1234, "R9 abort header");

    // R4: serial clocks with chip select high have no effect
    sclk = 1'b0; ticks(6);
    push(1'b0, 1'b0, 1'b0, "R4 idle clocks");
    sclk = 1'b1; ticks(6);
    checkRegs("R4 idle clocks");

    ticks(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule